// File: doc/BRIEF.md
# Packed Float Compare and Min/Max Unit

This block takes two 64-bit operands. Each operand packs two IEEE single-precision values: lane 0 sits in bits [31:0] and lane 1 in bits [63:32]. The block compares the operands lane by lane. A 3-bit function code chooses one of two kinds of result.

- A predicate (equal, greater, greater-or-equal) writes a mask of all ones or all zeros into each lane.
- A selection (maximum, minimum) writes the chosen operand value into each lane. This suits clamping and branch-free code.

Each lane has one sign-magnitude comparator. The comparator gives an equal flag and a greater flag, and both the mask path and the selection path use them. Ordering follows sign and magnitude, and positive zero equals negative zero. NaN inputs get no special treatment. The block reads no flags and writes none.

The result logic is purely combinational. A parameter can add one output register. That register clears to zero on an asynchronous active-low reset. A function code outside the five defined codes gives zero.

Top module: `pfcmp_unit`

## Requirements
- R1: Each 32-bit lane of the result depends only on the same lane of `src_a` and `src_b`. Lane 0 is bits [31:0] and lane 1 is bits [63:32].
- R2: With `fn_sel` = 3'b000 (equal), a lane is 32'hFFFFFFFF when the two lanes are equal and 32'h00000000 otherwise.
- R3: With `fn_sel` = 3'b001 (greater), a lane is 32'hFFFFFFFF when the `src_a` lane orders strictly above the `src_b` lane, and zero otherwise.
- R4: With `fn_sel` = 3'b010 (greater-or-equal), a lane is 32'hFFFFFFFF when the `src_a` lane orders above or equal to the `src_b` lane, and zero otherwise.
- R5: With `fn_sel` = 3'b011 (maximum), each lane carries the larger of the two inputs. On a tie it carries the `src_b` value.
- R6: With `fn_sel` = 3'b100 (minimum), each lane carries the smaller of the two inputs. On a tie it carries the `src_b` value.
- R7: Ordering uses the sign bit (bit 31) and the magnitude (bits 30:0). A positive value is above any negative value. Among negative values, the larger magnitude is lower. Two zeros of either sign are equal.
- R8: `fn_sel` codes 3'b101, 3'b110 and 3'b111 give a result of all zeros.
- R9: With `REG_OUT` = 1, `res` shows the result for the inputs sampled at the previous rising clock edge. While `rst_n` is low, `res` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| fn_sel | input | 3 | Function code: 000 eq, 001 gt, 010 ge, 011 max, 100 min |
| src_a | input | 64 | First operand, two single-precision lanes |
| src_b | input | 64 | Second operand, two single-precision lanes |
| res | output | 64 | Per-lane mask or selected value |

## Verification
The assertions check these properties on every cycle:

- A predicate result always has each lane either all ones or all zeros.
- Equal and greater-or-equal give all ones on identical inputs, and greater gives all zeros.
- Maximum and minimum only ever return one of the two lane inputs.
- Two zero inputs make maximum and minimum return the second operand.
- Undefined codes give zero.

Only the bench scenarios can show that the correct operand is chosen. This covers mixed signs, negative-magnitude ordering and lane independence, along with the one-cycle latency and the cleared value during reset.

// File: rtl/pfcmp_pkg.sv
package pfcmp_pkg;
    localparam int FN_W = 3;

    typedef enum logic [FN_W-1:0] {
        FN_EQ  = 3'b000,
        FN_GT  = 3'b001,
        FN_GE  = 3'b010,
        FN_MAX = 3'b011,
        FN_MIN = 3'b100
    } pf_fn_e;
endpackage

// File: rtl/pfcmp_order.sv
// Sign-magnitude ordering of one lane: a == b and a > b.
module pfcmp_order #(
    parameter int LANE_W = 32
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic              is_eq,
    output logic              is_gt
);
    localparam int MAG_W = LANE_W - 1;

    logic             sgn_a, sgn_b;
    logic [MAG_W-1:0] mag_a, mag_b;
    logic             both_zero;

    always_comb begin
        sgn_a     = a[LANE_W-1];
        sgn_b     = b[LANE_W-1];
        mag_a     = a[MAG_W-1:0];
        mag_b     = b[MAG_W-1:0];
        both_zero = (mag_a == '0) && (mag_b == '0);
        is_eq     = both_zero || (a == b);
        is_gt     = 1'b0;
        if (!both_zero) begin
            unique case ({sgn_a, sgn_b})
                2'b01:   is_gt = 1'b1;
                2'b00:   is_gt = mag_a > mag_b;
                2'b11:   is_gt = mag_a < mag_b;
                default: is_gt = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pfcmp_lane_fmt.sv
// Turns the ordering flags into a mask or a selected value.
module pfcmp_lane_fmt
    import pfcmp_pkg::*;
#(
    parameter int LANE_W = 32
) (
    input  logic [FN_W-1:0]   fn,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  logic              is_eq,
    input  logic              is_gt,
    output logic [LANE_W-1:0] y
);
    logic is_lt;

    always_comb begin
        is_lt = !is_eq && !is_gt;
        unique case (fn)
            FN_EQ:   y = {LANE_W{is_eq}};
            FN_GT:   y = {LANE_W{is_gt}};
            FN_GE:   y = {LANE_W{is_gt | is_eq}};
            FN_MAX:  y = is_gt ? a : b;
            FN_MIN:  y = is_lt ? a : b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/pfcmp_unit.sv
module pfcmp_unit
    import pfcmp_pkg::*;
#(
    parameter int LANES   = 2,
    parameter int LANE_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              fn_sel,
    input  logic [LANES*LANE_W-1:0] src_a,
    input  logic [LANES*LANE_W-1:0] src_b,
    output logic [LANES*LANE_W-1:0] res
);
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] res_comb;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] a_l, b_l;
        logic              eq_l, gt_l;

        assign a_l = src_a[g*LANE_W +: LANE_W];
        assign b_l = src_b[g*LANE_W +: LANE_W];

        pfcmp_order #(.LANE_W(LANE_W)) i_order (
            .a     (a_l),
            .b     (b_l),
            .is_eq (eq_l),
            .is_gt (gt_l)
        );

        pfcmp_lane_fmt #(.LANE_W(LANE_W)) i_fmt (
            .fn    (fn_sel),
            .a     (a_l),
            .b     (b_l),
            .is_eq (eq_l),
            .is_gt (gt_l),
            .y     (res_comb[g*LANE_W +: LANE_W])
        );
    end

    if (REG_OUT) begin : g_reg
        logic [DATA_W-1:0] res_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_comb;
        end
        assign res = res_q;
    end else begin : g_comb
        assign res = res_comb;
    end
endmodule

// File: rtl/pfcmp_unit_chk.sv
module pfcmp_unit_chk #(
    parameter int LANES   = 2,
    parameter int LANE_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [2:0]              fn_sel,
    input logic [LANES*LANE_W-1:0] src_a,
    input logic [LANES*LANE_W-1:0] src_b,
    input logic [LANES*LANE_W-1:0] res
);
    localparam int DATA_W = LANES * LANE_W;

    logic [2:0]        c_fn;
    logic [DATA_W-1:0] c_a, c_b;
    logic              c_ok;

    if (REG_OUT) begin : g_cap
        logic [2:0]        q_fn;
        logic [DATA_W-1:0] q_a, q_b;
        logic              q_ok;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_ok <= 1'b0;
                q_fn <= '0;
                q_a  <= '0;
                q_b  <= '0;
            end else begin
                q_ok <= 1'b1;
                q_fn <= fn_sel;
                q_a  <= src_a;
                q_b  <= src_b;
            end
        end
        assign c_fn = q_fn;
        assign c_a  = q_a;
        assign c_b  = q_b;
        assign c_ok = q_ok;
    end else begin : g_dir
        assign c_fn = fn_sel;
        assign c_a  = src_a;
        assign c_b  = src_b;
        assign c_ok = rst_n;
    end

    p_bad_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ok && c_fn > 3'd4) |-> res == '0);

    for (genvar g = 0; g < LANES; g++) begin : g_lchk
        logic [LANE_W-1:0] la, lb, ly;
        assign la = c_a[g*LANE_W +: LANE_W];
        assign lb = c_b[g*LANE_W +: LANE_W];
        assign ly = res[g*LANE_W +: LANE_W];

        p_mask_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (c_ok && c_fn <= 3'd2) |-> (ly == '1 || ly == '0));
        p_eq_same_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (c_ok && c_fn == 3'd0 && la == lb) |-> ly == '1);
        p_gt_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (c_ok && c_fn == 3'd1 && la == lb) |-> ly == '0);
        p_ge_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (c_ok && c_fn == 3'd2 && la == lb) |-> ly == '1);
        p_max_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (c_ok && c_fn == 3'd3) |-> (ly == la || ly == lb));
        p_min_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (c_ok && c_fn == 3'd4) |-> (ly == la || ly == lb));
        p_zero_tie_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (c_ok && (c_fn == 3'd3 || c_fn == 3'd4)
             && la[LANE_W-2:0] == '0 && lb[LANE_W-2:0] == '0) |-> ly == lb);
    end
endmodule

bind pfcmp_unit pfcmp_unit_chk #(
    .LANES(LANES), .LANE_W(LANE_W), .REG_OUT(REG_OUT)
) i_pfcmp_unit_chk (
    .clk(clk), .rst_n(rst_n), .fn_sel(fn_sel),
    .src_a(src_a), .src_b(src_b), .res(res)
);

// File: tb/test_pfcmp_unit.sv
module test_pfcmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fn_sel = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [63:0] res;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pfcmp_unit i_pfcmp_unit (
        .clk(clk), .rst_n(rst_n), .fn_sel(fn_sel),
        .src_a(src_a), .src_b(src_b), .res(res)
    );

    // {fn, a, b, expected}; lane1 = upper word, lane0 = lower word
    localparam int NV = 15;
    localparam logic [194:0] VEC [NV] = '{
        {3'd0, 64'h3F800000_40000000, 64'h3F800000_3F800000, 64'hFFFFFFFF_00000000}, // R2 R1
        {3'd0, 64'h00000000_80000000, 64'h80000000_00000000, 64'hFFFFFFFF_FFFFFFFF}, // R2 R7
        {3'd1, 64'h40000000_BF800000, 64'h3F800000_C0000000, 64'hFFFFFFFF_FFFFFFFF}, // R3 R7
        {3'd1, 64'hBF800000_3F800000, 64'h3F800000_3F800000, 64'h00000000_00000000}, // R3
        {3'd1, 64'h00000000_00000000, 64'h80000000_80000000, 64'h00000000_00000000}, // R3 R7
        {3'd2, 64'hBF800000_3F800000, 64'h3F800000_3F800000, 64'h00000000_FFFFFFFF}, // R4 R1
        {3'd2, 64'h80000000_C0000000, 64'h00000000_BF800000, 64'hFFFFFFFF_00000000}, // R4 R7
        {3'd3, 64'h40000000_C0000000, 64'h3F800000_BF800000, 64'h40000000_BF800000}, // R5
        {3'd3, 64'h00000000_80000000, 64'h80000000_00000000, 64'h80000000_00000000}, // R5 tie
        {3'd4, 64'h40000000_C0000000, 64'h3F800000_BF800000, 64'h3F800000_C0000000}, // R6
        {3'd4, 64'h00000000_3F000000, 64'h80000000_3F000000, 64'h80000000_3F000000}, // R6 tie
        {3'd4, 64'hBF800000_3F800000, 64'h3F000000_BF800000, 64'hBF800000_BF800000}, // R6 R1
        {3'd5, 64'h3F800000_3F800000, 64'h3F800000_3F800000, 64'h00000000_00000000}, // R8
        {3'd6, 64'h40000000_40000000, 64'h3F800000_3F800000, 64'h00000000_00000000}, // R8
        {3'd7, 64'hC0000000_40000000, 64'h3F800000_3F800000, 64'h00000000_00000000}  // R8
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        // R9: held in reset, inputs active, output stays zero
        src_a  = 64'h40000000_40000000;
        src_b  = 64'h3F800000_3F800000;
        fn_sel = 3'd3;
        repeat (2) @(posedge clk);
        #1 check("R9 reset", res, 64'h0);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            fn_sel = VEC[i][194:192];
            src_a  = VEC[i][191:128];
            src_b  = VEC[i][127:64];
            @(posedge clk);
            #1 check($sformatf("vec %0d fn %0d", i, VEC[i][194:192]), res, VEC[i][63:0]);
        end

        // R9: latency, new inputs not visible before the edge
        @(negedge clk);
        fn_sel = 3'd0;
        src_a  = 64'h12345678_9ABCDEF0;
        src_b  = 64'h12345678_9ABCDEF0;
        #1 check("R9 hold", res, 64'h0);
        @(posedge clk);
        #1 check("R9 R2 update", res, 64'hFFFFFFFF_FFFFFFFF);

        // R1: lane 1 changes, lane 0 result unchanged
        @(negedge clk);
        src_a = 64'h00000001_9ABCDEF0;
        @(posedge clk);
        #1 check("R1 lane isolate", res, 64'h00000000_FFFFFFFF);

        // R7: negative ordering by magnitude
        @(negedge clk);
        fn_sel = 3'd1;
        src_a  = 64'hC0400000_80000001;
        src_b  = 64'hC0800000_80000000;
        @(posedge clk);
        #1 check("R7 R3 neg mag", res, 64'hFFFFFFFF_00000000);

        // R9: asynchronous reset clears output
        @(negedge clk) rst_n = 1'b0;
        #1 check("R9 async clear", res, 64'h0);
        @(negedge clk) rst_n = 1'b1;

        finish_run();
    end

    initial begin
        #200us;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule